// File: doc/BRIEF.md
# Recirculating Serial Pattern Matcher

The block finds every position at which a target bit pattern of runtime length L occurs inside a stored data segment of SEG_LEN bits. It uses a single XNOR/AND comparison step, and the step count does not depend on L. The segment is replayed once for each target bit. On pass m, every segment bit A_k is compared with the target bit B_m. Each result is ANDed with the previous pass's result at position k-1. That previous result is kept in an SEG_LEN-bit loop store and read back through a one-bit delay register. After L passes, a 1 at position k means that A_{k-L+1}..A_k equal B_0..B_{L-1}. The flagged position is therefore the last bit of each occurrence, and one segment can contain several occurrences.

Software shifts the segment in serially while the block is idle. It then presents the target and its length and pulses start. The final pass produces one output bit per cycle, with the bit position alongside it. A done pulse marks the last output bit. A search takes L·SEG_LEN cycles.

Top module: `pm_matcher`

## Requirements
- R1: While idle, each cycle with seg_load_valid high shifts seg_load_bit into the segment. After SEG_LEN loads, the first loaded bit is A_0 and the last loaded bit is A_{SEG_LEN-1}.
- R2: A start pulse while idle, with tgt_len between 1 and TGT_MAX, captures tgt_bits and begins a search. Bit m of tgt_bits is B_m. A start with tgt_len of 0 or above TGT_MAX is ignored: busy stays low and no output appears.
- R3: On the final pass, match_bit at position k is 1 exactly when A_{k-L+1+j} equals B_j for every j in 0..L-1. Every such position is flagged.
- R4: Matches never wrap from the end of the segment to its start. Positions k < L-1 always report 0.
- R5: match_valid is high only during the final pass, for exactly SEG_LEN consecutive cycles, with match_idx rising from 0 to SEG_LEN-1. match_bit is 0 whenever match_valid is low.
- R6: If start is sampled at clock edge S, the output for position k of the final pass appears after edge S+1+(L-1)·SEG_LEN+k. done is a one-cycle pulse coinciding with match_idx = SEG_LEN-1, at edge S+L·SEG_LEN, and busy falls at that same edge.
- R7: While busy, start, tgt_bits and tgt_len have no effect on the running search.
- R8: While busy, seg_load_valid has no effect on the stored segment.
- R9: With L = 1, match_bit at position k equals A_k XNOR B_0.
- R10: When a search completes, the loop store and the delay bit are cleared, so a following search is unaffected by earlier results.
- R11: After reset, busy, match_valid, match_bit and done are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| seg_load_valid | input | 1 | Shift one segment bit in (idle only) |
| seg_load_bit | input | 1 | Segment bit being loaded |
| tgt_bits | input | TGT_MAX | Target pattern, bit m is B_m |
| tgt_len | input | $clog2(TGT_MAX+1) | Target length L |
| start | input | 1 | Begin a search |
| busy | output | 1 | Search in progress |
| match_valid | output | 1 | Final-pass output bit is valid |
| match_bit | output | 1 | 1 when an occurrence ends at match_idx |
| match_idx | output | $clog2(SEG_LEN) | Segment position of match_bit |
| done | output | 1 | Pulse with the last final-pass bit |

## Verification
The assertions check several rules on every cycle. Final-pass outputs appear only after a final-pass step. The done pulse coincides with the last segment position and ends busy. Output indices rise one per cycle. The first position of every later pass never produces a match. The captured target holds steady while busy. The loop store is empty whenever the block is idle. Other properties depend on chosen data and can only be shown by the bench's scenarios. These are the correctness of the match bits against a restated window comparison, the refusal of illegal lengths, the absence of wrap-around matches, the ignoring of loads and starts during a search, and the exact cycle at which each output appears.

// File: rtl/pm_pkg.sv
`timescale 1ns/1ps
package pm_pkg;

  typedef enum logic [0:0] {
    PM_IDLE = 1'b0,
    PM_RUN  = 1'b1
  } pm_state_e;

  // One comparison step: enable ANDed with equality of data and target bit.
  function automatic logic pm_step(input logic en, input logic a, input logic b);
    return en & ~(a ^ b);
  endfunction

  // A target length is usable when it lies in 1..max_len.
  function automatic logic pm_len_legal(input logic [31:0] len, input logic [31:0] max_len);
    return (len >= 32'd1) && (len <= max_len);
  endfunction

  // Enable used on a pass: forced on pass 0, zero at position 0 later.
  function automatic logic pm_enable(input logic first, input logic at_head, input logic fed_back);
    if (first) return 1'b1;
    if (at_head) return 1'b0;
    return fed_back;
  endfunction

endpackage

// File: rtl/pm_seg_store.sv
`timescale 1ns/1ps
module pm_seg_store #(
  parameter int SEG_LEN = 16,
  localparam int IDX_W = (SEG_LEN > 1) ? $clog2(SEG_LEN) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift_en,
  input  logic             shift_bit,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_bit
);

  logic [SEG_LEN-1:0] seg_q;

  // New bits enter at the top; after SEG_LEN shifts the first one sits at 0.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seg_q <= '0;
    end else if (shift_en) begin
      seg_q <= {shift_bit, seg_q[SEG_LEN-1:1]};
    end
  end

  assign rd_bit = seg_q[rd_idx];

endmodule

// File: rtl/pm_pass_ctrl.sv
`timescale 1ns/1ps
module pm_pass_ctrl
  import pm_pkg::*;
#(
  parameter int SEG_LEN = 16,
  parameter int TGT_MAX = 8,
  localparam int IDX_W  = (SEG_LEN > 1) ? $clog2(SEG_LEN) : 1,
  localparam int LEN_W  = $clog2(TGT_MAX + 1),
  localparam int PASS_W = (TGT_MAX > 1) ? $clog2(TGT_MAX) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [LEN_W-1:0]  len_in,
  output logic              busy,
  output logic [IDX_W-1:0]  step_k,
  output logic [PASS_W-1:0] pass_m,
  output logic              first_pass,
  output logic              last_pass,
  output logic              launch,
  output logic              finish
);

  pm_state_e         state_q;
  logic [LEN_W-1:0]  len_q;
  logic [LEN_W-1:0]  len_m1;
  logic              at_tail;

  assign busy       = (state_q == PM_RUN);
  assign len_m1     = len_q - 1'b1;
  assign first_pass = (pass_m == '0);
  assign last_pass  = (LEN_W'(pass_m) == len_m1);
  assign at_tail    = (step_k == IDX_W'(SEG_LEN - 1));
  assign launch     = !busy && start && pm_len_legal(32'(len_in), 32'(TGT_MAX));
  assign finish     = busy && last_pass && at_tail;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PM_IDLE;
      len_q   <= LEN_W'(1);
      step_k  <= '0;
      pass_m  <= '0;
    end else if (launch) begin
      state_q <= PM_RUN;
      len_q   <= len_in;
      step_k  <= '0;
      pass_m  <= '0;
    end else if (busy) begin
      if (at_tail) begin
        step_k <= '0;
        if (last_pass) begin
          state_q <= PM_IDLE;
          pass_m  <= '0;
        end else begin
          pass_m <= pass_m + 1'b1;
        end
      end else begin
        step_k <= step_k + 1'b1;
      end
    end
  end

endmodule

// File: rtl/pm_loop_cell.sv
`timescale 1ns/1ps
module pm_loop_cell
  import pm_pkg::*;
#(
  parameter int SEG_LEN = 16,
  localparam int IDX_W = (SEG_LEN > 1) ? $clog2(SEG_LEN) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active,
  input  logic             clear,
  input  logic             first_pass,
  input  logic [IDX_W-1:0] step_k,
  input  logic             a_bit,
  input  logic             b_bit,
  output logic             y
);

  logic [SEG_LEN-1:0] loop_q;
  logic [SEG_LEN-1:0] wr_sel;
  logic               dly_q;
  logic               en_w;

  // One write strobe per loop position.
  for (genvar i = 0; i < SEG_LEN; i++) begin : g_sel
    assign wr_sel[i] = active && (step_k == IDX_W'(i));
  end

  assign en_w = pm_enable(first_pass, step_k == '0, dly_q);
  assign y    = pm_step(en_w, a_bit, b_bit);

  // The old value at k is moved into the delay bit as Y overwrites it,
  // so step k+1 sees the previous pass's result at k.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      loop_q <= '0;
      dly_q  <= 1'b0;
    end else if (clear) begin
      loop_q <= '0;
      dly_q  <= 1'b0;
    end else if (active) begin
      loop_q <= (loop_q & ~wr_sel) | (wr_sel & {SEG_LEN{y}});
      dly_q  <= loop_q[step_k];
    end
  end

endmodule

// File: rtl/pm_matcher.sv
`timescale 1ns/1ps
module pm_matcher #(
  parameter int SEG_LEN = 16,
  parameter int TGT_MAX = 8,
  localparam int IDX_W  = (SEG_LEN > 1) ? $clog2(SEG_LEN) : 1,
  localparam int LEN_W  = $clog2(TGT_MAX + 1),
  localparam int PASS_W = (TGT_MAX > 1) ? $clog2(TGT_MAX) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               seg_load_valid,
  input  logic               seg_load_bit,
  input  logic [TGT_MAX-1:0] tgt_bits,
  input  logic [LEN_W-1:0]   tgt_len,
  input  logic               start,
  output logic               busy,
  output logic               match_valid,
  output logic               match_bit,
  output logic [IDX_W-1:0]   match_idx,
  output logic               done
);

  logic               busy_w;
  logic [IDX_W-1:0]   step_k;
  logic [PASS_W-1:0]  pass_m;
  logic               first_pass;
  logic               last_pass;
  logic               launch;
  logic               finish;
  logic               seg_shift;
  logic               a_bit;
  logic               b_bit;
  logic               y_w;
  logic [TGT_MAX-1:0] tgt_q;

  assign seg_shift = seg_load_valid && !busy_w;
  assign b_bit     = tgt_q[pass_m];
  assign busy      = busy_w;

  pm_pass_ctrl #(.SEG_LEN(SEG_LEN), .TGT_MAX(TGT_MAX)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .len_in     (tgt_len),
    .busy       (busy_w),
    .step_k     (step_k),
    .pass_m     (pass_m),
    .first_pass (first_pass),
    .last_pass  (last_pass),
    .launch     (launch),
    .finish     (finish)
  );

  pm_seg_store #(.SEG_LEN(SEG_LEN)) u_seg (
    .clk       (clk),
    .rst_n     (rst_n),
    .shift_en  (seg_shift),
    .shift_bit (seg_load_bit),
    .rd_idx    (step_k),
    .rd_bit    (a_bit)
  );

  pm_loop_cell #(.SEG_LEN(SEG_LEN)) u_loop (
    .clk        (clk),
    .rst_n      (rst_n),
    .active     (busy_w),
    .clear      (finish),
    .first_pass (first_pass),
    .step_k     (step_k),
    .a_bit      (a_bit),
    .b_bit      (b_bit),
    .y          (y_w)
  );

  // Target captured at launch only.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgt_q <= '0;
    end else if (launch) begin
      tgt_q <= tgt_bits;
    end
  end

  // Final-pass outputs registered one cycle after each step.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      match_valid <= 1'b0;
      match_bit   <= 1'b0;
      match_idx   <= '0;
      done        <= 1'b0;
    end else begin
      match_valid <= busy_w && last_pass;
      match_bit   <= busy_w && last_pass && y_w;
      match_idx   <= step_k;
      done        <= finish;
    end
  end

endmodule

// File: rtl/pm_matcher_chk.sv
`timescale 1ns/1ps
module pm_matcher_chk #(
  parameter int SEG_LEN = 16,
  parameter int TGT_MAX = 8,
  localparam int IDX_W  = (SEG_LEN > 1) ? $clog2(SEG_LEN) : 1
) (
  input logic               clk,
  input logic               rst_n,
  input logic               busy,
  input logic               finish,
  input logic               last_pass,
  input logic               first_pass,
  input logic [IDX_W-1:0]   step_k,
  input logic               y_w,
  input logic [TGT_MAX-1:0] tgt_q,
  input logic [SEG_LEN-1:0] loop_mem,
  input logic               loop_dly,
  input logic               match_valid,
  input logic [IDX_W-1:0]   match_idx,
  input logic               done
);

  a_r5_valid_from_final_pass: assert property (@(posedge clk) disable iff (!rst_n)
    match_valid |-> $past(busy && last_pass));

  a_r5_idx_ascending: assert property (@(posedge clk) disable iff (!rst_n)
    (match_valid && $past(match_valid)) |-> (match_idx == IDX_W'($past(match_idx) + 1'b1)));

  a_r6_done_at_tail: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (match_valid && (match_idx == IDX_W'(SEG_LEN - 1))));

  a_r6_finish_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
    finish |=> (done && !busy));

  a_r4_no_wrap_at_head: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !first_pass && (step_k == '0)) |-> !y_w);

  a_r7_target_held: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !finish) |=> $stable(tgt_q));

  a_r10_loop_empty_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> ((loop_mem == '0) && !loop_dly));

endmodule

bind pm_matcher pm_matcher_chk #(.SEG_LEN(SEG_LEN), .TGT_MAX(TGT_MAX)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .busy        (busy_w),
  .finish      (finish),
  .last_pass   (last_pass),
  .first_pass  (first_pass),
  .step_k      (step_k),
  .y_w         (y_w),
  .tgt_q       (tgt_q),
  .loop_mem    (u_loop.loop_q),
  .loop_dly    (u_loop.dly_q),
  .match_valid (match_valid),
  .match_idx   (match_idx),
  .done        (done)
);

// File: tb/pm_matcher_tb_top.sv
`timescale 1ns/1ps
module pm_matcher_tb_top;

  localparam int N  = 16;
  localparam int TM = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       seg_load_valid = 1'b0;
  logic       seg_load_bit = 1'b0;
  logic [7:0] tgt_bits = '0;
  logic [3:0] tgt_len = '0;
  logic       start = 1'b0;
  logic       busy;
  logic       match_valid;
  logic       match_bit;
  logic [3:0] match_idx;
  logic       done;

  int n_cmp = 0;
  int n_bad = 0;
  logic [N-1:0] seg_ref = '0;

  always #2 clk = ~clk;

  pm_matcher #(.SEG_LEN(N), .TGT_MAX(TM)) dut_i (
    .clk(clk), .rst_n(rst_n), .seg_load_valid(seg_load_valid),
    .seg_load_bit(seg_load_bit), .tgt_bits(tgt_bits), .tgt_len(tgt_len),
    .start(start), .busy(busy), .match_valid(match_valid),
    .match_bit(match_bit), .match_idx(match_idx), .done(done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Window comparison ending at position k.
  function automatic logic window_hit(input logic [N-1:0] s, input logic [7:0] t, input int len, input int k);
    if (k < len - 1) return 1'b0;
    for (int j = 0; j < len; j++)
      if (s[k - len + 1 + j] != t[j]) return 1'b0;
    return 1'b1;
  endfunction

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(busy == 1'b0,        "R11 busy",        busy, 0);
    chk(match_valid == 1'b0, "R11 match_valid", match_valid, 0);
    chk(match_bit == 1'b0,   "R11 match_bit",   match_bit, 0);
    chk(done == 1'b0,        "R11 done",        done, 0);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_load(input logic [N-1:0] v);
    for (int i = 0; i < N; i++) begin
      seg_load_valid = 1'b1;
      seg_load_bit   = v[i];
      @(negedge clk);
    end
    seg_load_valid = 1'b0;
    seg_ref = v;
  endtask

  task automatic t_search(input logic [7:0] tgt, input int len, input bit disturb, input string tag);
    int total;
    int bad_start;
    logic ev, eb, ed;
    int ei;
    string rq;
    total = len * N;
    tgt_bits = tgt;
    tgt_len  = 4'(len);
    start    = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, {"R2 busy after start ", tag}, busy, 1);
    bad_start = 0;
    for (int t = 1; t <= total; t++) begin
      if (disturb && t < total) begin
        start          = 1'b1;
        tgt_bits       = ~tgt;
        tgt_len        = 4'((len % TM) + 1);
        seg_load_valid = 1'b1;
        seg_load_bit   = t[0];
      end else begin
        start          = 1'b0;
        tgt_bits       = tgt;
        tgt_len        = 4'(len);
        seg_load_valid = 1'b0;
      end
      @(negedge clk);
      ev = (t > (len - 1) * N);
      ei = (t - 1) % N;
      ed = (t == total);
      eb = ev ? window_hit(seg_ref, tgt, len, ei) : 1'b0;
      chk(match_valid == ev, {"R5 R6 match_valid ", tag}, match_valid, ev);
      chk(done == ed,        {"R6 done ", tag}, done, ed);
      if (ev) begin
        chk(int'(match_idx) == ei, {"R5 match_idx ", tag}, match_idx, ei);
        if (len == 1)        rq = "R9 R1 match_bit ";
        else if (ei < len-1) rq = "R4 match_bit ";
        else                 rq = "R3 match_bit ";
        if (disturb) rq = {"R7 R8 ", rq};
        chk(match_bit == eb, {rq, tag}, match_bit, eb);
      end else begin
        chk(match_bit == 1'b0, {"R5 match_bit idle ", tag}, match_bit, 0);
      end
    end
    start = 1'b0;
    seg_load_valid = 1'b0;
    chk(busy == 1'b0, {"R6 busy after done ", tag}, busy, 0);
    @(negedge clk);
    chk(match_valid == 1'b0, {"R5 quiet after done ", tag}, match_valid, 0);
  endtask

  task automatic t_bad_len(input int len);
    tgt_len  = 4'(len);
    tgt_bits = 8'hA5;
    start    = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b0, "R2 illegal length ignored", busy, 0);
    repeat (3) @(negedge clk);
    chk(match_valid == 1'b0 && done == 1'b0, "R2 no output for illegal length",
        int'(match_valid) + int'(done), 0);
  endtask

  initial begin
    logic [N-1:0] seg_a;
    logic [N-1:0] seg_w;
    logic [7:0]   t8;
    // A_0..A_15 = 1,0,1,1,0,1,0,1,1,0,0,1,0,1,1,1
    seg_a = 16'b1110_1001_1010_1101;
    // Only a wrapped window (A13,A14,A15,A0) would spell 1,0,1,1
    seg_w = 16'b1010_0000_0000_0001;
    t_reset();
    t_load(seg_a);
    t_search(8'b0000_1101, 4, 1'b0, "multi");
    t_search(8'b0000_0000, 1, 1'b0, "len1 b0=0");
    t_search(8'b0000_0001, 1, 1'b0, "len1 b0=1");
    t8 = seg_a[13:6];
    t_search(t8, 8, 1'b0, "len max");
    t_search(8'b0000_0011, 2, 1'b0, "len2");
    t_bad_len(0);
    t_bad_len(9);
    t_search(8'b0000_1101, 4, 1'b1, "disturbed");
    t_search(8'b0000_1101, 4, 1'b0, "R10 repeat");
    t_load(seg_w);
    t_search(8'b0000_1101, 4, 1'b0, "R4 wrap");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(4 * 100000);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule